// File: doc/BRIEF.md
# Timer Count-Clock Edge Selector

This block feeds a timer counter with a one-cycle count-enable strobe. An 8-bit control register holds the counter's clock configuration. A 3-bit source field picks one of three taps of a free-running divider, the undivided system clock, or a cascade input that carries another channel's overflow or underflow. A 2-bit edge field then chooses whether the counter advances on rising, falling or both transitions of that source. The remaining 3-bit field selects the clear source. This block only stores it, and the counter's clear logic decodes it.

The edge field is honoured only for the divided taps. With the undivided clock or the cascade input selected, the field still reads back exactly as written, but counting behaves as if it held its reset value. A phase-mode input hands counting over to an external phase decoder and silences the strobe. A run input marks the counter as running. Writes made while it is high still take effect, but they set a sticky flag so that the misuse is visible.

Top module: `tmr_cclk_sel`

## Requirements
- R1: After reset, rd_data is 8'h00, cnt_en is low and wr_while_run is low.
- R2: A write (wr_en high at a clock edge) stores wr_data, and rd_data returns exactly that byte from the next cycle on, whatever the source. Field positions are clear select [7:5], edge select [4:3] and source select [2:0].
- R3: With edge select 00 and source 001, 010 or 011, cnt_en pulses once per 4, 16 or 64 clock cycles, on rising transitions of the divided level.
- R4: With edge select 01, the rate is the same as in R3, and each pulse falls half a source period away from the rising-edge pulse position.
- R5: With edge select 10 or 11 on a divided source, cnt_en pulses twice per source period, at both transition positions.
- R6: With source 000, cnt_en is high every cycle while counting is allowed, whatever the edge select.
- R7: With source 100, cnt_en pulses once per rising transition of casc_in, whatever the edge select.
- R8: Source codes 101, 110 and 111 never produce a pulse.
- R9: While phase_mode is high, cnt_en stays low.
- R10: While run is low, cnt_en stays low.
- R11: A write with run high sets wr_while_run, and the write still takes effect. A write with run low leaves the flag unchanged. Only reset clears the flag.
- R12: For any source other than 000, cnt_en is never high in two consecutive cycles once the configuration has been stable for two cycles.
- R13: cnt_en is registered. It reflects run, phase_mode and the source state of the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data |
| rd_data | output | 8 | Control register contents |
| run | input | 1 | Counter running indication |
| phase_mode | input | 1 | Phase-counting override; silences the strobe |
| casc_in | input | 1 | Cascade overflow/underflow level from another channel |
| cnt_en | output | 1 | One-cycle count-enable strobe |
| wr_while_run | output | 1 | Sticky flag: register written while running |

## Verification
Two functions can fall in the same cycle: a register write and live counting. The bench provokes this by writing a new source and edge setting while run is high. It then judges the write by the sticky flag and by the register readback, and it judges the strobe rate over the next 256 cycles against the newly written configuration. A sweep over every edge and source code also shows that an ignored edge field still reads back intact while counting follows the forced rising-edge rule.

// File: rtl/tmr_cclk_sel.sv
module tmr_cclk_sel #(
  parameter int TAP_A = 1,
  parameter int TAP_B = 3,
  parameter int TAP_C = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       run,
  input  logic       phase_mode,
  input  logic       casc_in,
  output logic       cnt_en,
  output logic       wr_while_run
);
  localparam int DIV_W = TAP_C + 1;
  localparam logic [2:0] SRC_FULL = 3'd0;
  localparam logic [2:0] SRC_CASC = 3'd4;

  logic [7:0]       ctrl;
  logic [DIV_W-1:0] div;
  logic             casc_s, lvl, lvl_q, hit;
  logic [1:0]       esel;

  wire [2:0] src  = ctrl[2:0];
  wire       rise = lvl & ~lvl_q;
  wire       fall = ~lvl & lvl_q;

  assign rd_data = ctrl;
  assign esel = (src == SRC_FULL || src == SRC_CASC) ? 2'b00 : ctrl[4:3];

  always_comb begin
    case (src)
      3'd1:    lvl = div[TAP_A];
      3'd2:    lvl = div[TAP_B];
      3'd3:    lvl = div[TAP_C];
      SRC_CASC: lvl = casc_s;
      default: lvl = 1'b0;
    endcase
  end

  always_comb begin
    if (src == SRC_FULL)      hit = 1'b1;
    else if (src > SRC_CASC)  hit = 1'b0;
    else begin
      case (esel)
        2'b00:   hit = rise;
        2'b01:   hit = fall;
        default: hit = rise | fall;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl         <= '0;
      div          <= '0;
      casc_s       <= 1'b0;
      lvl_q        <= 1'b0;
      cnt_en       <= 1'b0;
      wr_while_run <= 1'b0;
    end else begin
      div    <= div + 1'b1;
      casc_s <= casc_in;
      lvl_q  <= lvl;
      cnt_en <= run & ~phase_mode & hit;
      if (wr_en) begin
        ctrl <= wr_data;
        if (run) wr_while_run <= 1'b1;
      end
    end
  end

  p_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == $past(wr_data));
  p_full_every_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !phase_mode && rd_data[2:0] == 3'd0) |=> cnt_en);
  p_idle_codes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[2:0] > 3'd4) |=> !cnt_en);
  p_phase_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    phase_mode |=> !cnt_en);
  p_run_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !cnt_en);
  p_flag_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && run) |=> wr_while_run);
  p_flag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_while_run |=> wr_while_run);
  p_single_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && rd_data[2:0] != 3'd0 && !wr_en && !$past(wr_en) && !$past(wr_en, 2))
    |=> !cnt_en);
  p_registered_r13: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en |-> ($past(run) && !$past(phase_mode)));
endmodule

// File: tb/tmr_cclk_sel_test.sv
module tmr_cclk_sel_test;
  logic clk = 0, rst_n = 0, wr_en = 0, run = 0, phase_mode = 0, casc_in = 0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic cnt_en, wr_while_run;
  int total = 0, fails = 0, cyc = 0;
  bit casc_on = 0, done = 0;

  tmr_cclk_sel uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .run(run), .phase_mode(phase_mode), .casc_in(casc_in),
    .cnt_en(cnt_en), .wr_while_run(wr_while_run));

  always #10 clk = ~clk;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    casc_in <= casc_on && ((cyc % 8) < 3);
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); wr_en = 1; wr_data = v;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic measure(output int n, output int dbl, output int first);
    logic prev = 0;
    n = 0; dbl = 0; first = -1;
    run = 1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      if (cnt_en) begin
        if (first < 0) first = cyc;
        if (prev) dbl++;
        n++;
      end
      prev = cnt_en;
    end
    run = 0;
    @(negedge clk);
  endtask

  function automatic int expect_rate(input int e, input int p);
    int per;
    if (p == 0) return 256;
    if (p == 4) return 32;
    if (p > 4) return 0;
    per = 1 << (2 * p);
    return (e >= 2) ? 512 / per : 256 / per;
  endfunction

  initial begin
    int n, dbl, fr, ff;
    casc_on = 1;
    repeat (3) @(negedge clk);
    chk("R1 rd_data", rd_data, 0);
    chk("R1 cnt_en", cnt_en, 0);
    chk("R1 flag", wr_while_run, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk("R1 cnt_en after release", cnt_en, 0);

    for (int e = 0; e < 4; e++) begin
      for (int p = 0; p < 8; p++) begin
        logic [7:0] v;
        v = {3'((e * 3 + p) % 8), 2'(e), 3'(p)};
        wr(v);
        chk($sformatf("R2 readback e%0d p%0d", e, p), rd_data, v);
        measure(n, dbl, fr);
        chk($sformatf("R3 R4 R5 R6 R7 R8 rate e%0d p%0d", e, p), n, expect_rate(e, p));
        if (p != 0) chk($sformatf("R12 back-to-back e%0d p%0d", e, p), dbl, 0);
      end
    end
    chk("R11 no flag for stopped writes", wr_while_run, 0);

    for (int p = 1; p < 3; p++) begin
      int per;
      per = 1 << (2 * p);
      wr({3'd0, 2'b00, 3'(p)}); measure(n, dbl, fr);
      wr({3'd0, 2'b01, 3'(p)}); measure(n, dbl, ff);
      chk($sformatf("R4 falling offset p%0d", p), ((ff - fr) % per + per) % per, per / 2);
      wr({3'd0, 2'b10, 3'(p)}); measure(n, dbl, n);
      chk($sformatf("R5 both-edge first at rise or fall p%0d", p),
          (((n - fr) % per + per) % per) % (per / 2), 0);
    end

    wr(8'h00);
    repeat (64) begin @(negedge clk); chk("R10 stopped", cnt_en, 0); end
    phase_mode = 1; run = 1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 32; i++) begin @(negedge clk); chk("R9 phase override", cnt_en, 0); end
    phase_mode = 0;
    @(negedge clk); @(negedge clk);
    chk("R13 resumes after phase drop", cnt_en, 1);
    @(negedge clk); run = 0;
    @(negedge clk);
    chk("R13 cnt_en falls one edge after run", cnt_en, 0);

    run = 1;
    @(negedge clk); wr_en = 1; wr_data = 8'b101_11_010;
    @(negedge clk); wr_en = 0;
    chk("R11 flag set by running write", wr_while_run, 1);
    chk("R11 running write applied", rd_data, 8'b101_11_010);
    measure(n, dbl, fr);
    chk("R11 new config rate", n, 32);
    wr(8'h01);
    chk("R11 flag sticky", wr_while_run, 1);
    rst_n = 0; @(negedge clk);
    chk("R11 flag cleared by reset", wr_while_run, 0);
    chk("R1 rd_data after second reset", rd_data, 0);
    rst_n = 1;

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule